// File: doc/BRIEF.md
# SD SPI Command Issue Engine

This block sends one SD/MMC command to a card in SPI mode and returns the card's one-byte R1 status. A start strobe delivers a 6-bit command index and a 32-bit argument. The engine then pushes a seven-byte frame through a byte-exchange shifter below it: a filler byte, the command byte, the argument split into four bytes, and a closing byte that carries the CRC7 checksum. The checksum is built as the command and argument bytes leave, so no extra pass over the frame is needed.

After the frame, the engine keeps clocking filler bytes and scans the bytes it receives for the R1 status. The byte that comes back during the first poll transfer is never taken as the status. A later byte with its top bit clear is the status and ends the command. If the poll budget runs out first, the last byte received is reported, and a value of all ones marks a missing card. R1 bits have these meanings: bit0 idle, bit1 erase reset, bit2 illegal command, bit3 CRC error, bit4 erase sequence error, bit5 address error, bit6 parameter error. The host logic above the engine decodes them.

Every byte goes through a valid/ready exchange. The engine holds `xfer_valid_o` and `xfer_tx_o` until the shifter raises `xfer_ready_i` for one cycle. During that cycle `xfer_rx_i` holds the byte that was received in return.

Top module: `sdspi_cmd_engine`

## Requirements
- R1: The first byte of each frame is 0xFF. The second byte is 0x40 OR the 6-bit command index, which gives bit 7 = 0 and bit 6 = 1.
- R2: Bytes three to six carry the 32-bit argument, most significant byte first.
- R3: The seventh byte is {crc7, 1'b1}. crc7 uses the polynomial x^7+x^3+1, starts from zero, and covers the command byte and the four argument bytes, MSB first (for example index 0 with argument 0 gives 0x95, and index 8 with argument 0x1AA gives 0x87).
- R4: After the frame, the engine sends 0xFF in each poll transfer. It makes at most POLL_BYTES poll transfers (default 8).
- R5: The byte received in the first poll transfer is never accepted as R1, even when its bit 7 is clear.
- R6: The first later poll byte with bit 7 clear ends the command. r1_o takes that byte, and no further transfer is requested.
- R7: If the budget runs out with no accepted byte, r1_o takes the byte from the last poll transfer. no_resp_o is 1 exactly when that byte is 0xFF.
- R8: done_o is a one-cycle pulse in the cycle after the handshake of the final poll transfer. r1_o and no_resp_o are valid in that cycle and hold until the next done_o.
- R9: busy_o rises in the cycle after an accepted start and falls in the cycle done_o rises. A start while busy_o is high has no effect.
- R10: After reset, busy_o, done_o, xfer_valid_o and no_resp_o are 0 and r1_o is 0xFF.
- R11: Once xfer_valid_o is high, it stays high and xfer_tx_o stays stable until a cycle with xfer_ready_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, taken only while idle |
| cmd_idx_i | input | 6 | Command index |
| cmd_arg_i | input | 32 | Command argument |
| busy_o | output | 1 | Command in progress |
| xfer_valid_o | output | 1 | Byte exchange requested |
| xfer_tx_o | output | 8 | Byte to transmit |
| xfer_ready_i | input | 1 | Exchange complete, rx byte valid this cycle |
| xfer_rx_i | input | 8 | Byte received during the exchange |
| r1_o | output | 8 | Reported status byte |
| no_resp_o | output | 1 | No card answered (reported byte is 0xFF) |
| done_o | output | 1 | Command finished, one-cycle pulse |

## Verification
The frame bytes and the poll bytes are checked when they are handed over, at each handshake. done_o, r1_o and no_resp_o are due exactly one cycle after the handshake of the final poll byte. The bench logs the cycle of every handshake, samples done_o on the falling edge, and requires the pulse to fall exactly one cycle after the last logged exchange. After each command it waits a few more cycles and then counts the exchanges, to confirm that none was requested after the accepting byte.

// File: rtl/sdspi_cmd_pkg.sv
package sdspi_cmd_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_FRAME = 2'd1,
      PH_POLL  = 2'd2
   } phase_e;

   localparam logic [7:0] FILL_BYTE  = 8'hFF;
   localparam logic [1:0] CMD_PREFIX = 2'b01;
   localparam logic [6:0] CRC7_POLY  = 7'h09;
   localparam int         FRAME_LEN  = 7;

   // One message bit into the CRC7 register, MSB-first
   function automatic logic [6:0] crc7_bit(input logic [6:0] c, input logic b);
      logic fb;
      fb = c[6] ^ b;
      return {c[5:0], 1'b0} ^ (fb ? CRC7_POLY : 7'h00);
   endfunction

   function automatic logic [6:0] crc7_byte(input logic [6:0] c, input logic [7:0] d);
      logic [6:0] r;
      r = c;
      for (int i = 7; i >= 0; i--) r = crc7_bit(r, d[i]);
      return r;
   endfunction

endpackage

// File: rtl/sdspi_crc7.sv
module sdspi_crc7
   import sdspi_cmd_pkg::*;
#(
   parameter int BIT_SERIAL = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr_i,
   input  logic       upd_i,
   input  logic [7:0] data_i,
   output logic       rdy_o,
   output logic [6:0] crc_o
);

   generate
      if (BIT_SERIAL != 0 && BIT_SERIAL != 1) begin : g_bad_variant
         $error("sdspi_crc7: BIT_SERIAL must be 0 or 1");
      end

      if (BIT_SERIAL == 0) begin : g_byte
         logic [6:0] crc_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     crc_q <= '0;
            else if (clr_i) crc_q <= '0;
            else if (upd_i) crc_q <= crc7_byte(crc_q, data_i);
         end
         assign crc_o = crc_q;
         assign rdy_o = 1'b1;
      end else begin : g_serial
         logic [6:0] crc_q;
         logic [7:0] sh_q;
         logic [3:0] left_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               crc_q  <= '0;
               sh_q   <= '0;
               left_q <= '0;
            end else if (clr_i) begin
               crc_q  <= '0;
               left_q <= '0;
            end else if (upd_i) begin
               sh_q   <= data_i;
               left_q <= 4'd8;
            end else if (left_q != 4'd0) begin
               crc_q  <= crc7_bit(crc_q, sh_q[7]);
               sh_q   <= {sh_q[6:0], 1'b0};
               left_q <= left_q - 4'd1;
            end
         end
         assign crc_o = crc_q;
         assign rdy_o = (left_q == 4'd0);

         assert_upd_when_rdy_R3: assert property (@(posedge clk) disable iff (!rst_n)
            upd_i |-> rdy_o)
            else $error("CRC update while serial CRC still shifting");
      end
   endgenerate

endmodule

// File: rtl/sdspi_frame_seq.sv
module sdspi_frame_seq
   import sdspi_cmd_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        go_i,
   input  logic [5:0]  idx_i,
   input  logic [31:0] arg_i,
   input  logic [6:0]  crc_i,
   input  logic        crc_rdy_i,
   input  logic        ready_i,
   output logic        valid_o,
   output logic [7:0]  tx_o,
   output logic        crc_upd_o,
   output logic        fin_o
);

   localparam int PW = $clog2(FRAME_LEN);
   localparam logic [PW-1:0] LAST_POS = PW'(FRAME_LEN - 1);

   logic          active_q;
   logic [PW-1:0] pos_q;
   logic          hs;

   always_comb begin
      unique case (pos_q)
         PW'(0):  tx_o = FILL_BYTE;
         PW'(1):  tx_o = {CMD_PREFIX, idx_i};
         PW'(2):  tx_o = arg_i[31:24];
         PW'(3):  tx_o = arg_i[23:16];
         PW'(4):  tx_o = arg_i[15:8];
         PW'(5):  tx_o = arg_i[7:0];
         default: tx_o = {crc_i, 1'b1};
      endcase
   end

   // Hold off each byte until the checksum unit can take the next one
   assign valid_o   = active_q && crc_rdy_i;
   assign hs        = valid_o && ready_i;
   assign crc_upd_o = hs && (pos_q != PW'(0)) && (pos_q != LAST_POS);
   assign fin_o     = hs && (pos_q == LAST_POS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         pos_q    <= '0;
      end else if (go_i) begin
         active_q <= 1'b1;
         pos_q    <= '0;
      end else if (hs) begin
         if (pos_q == LAST_POS) active_q <= 1'b0;
         else                   pos_q    <= pos_q + PW'(1);
      end
   end

   assert_lead_fill_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && pos_q == PW'(0)) |-> tx_o == FILL_BYTE)
      else $error("frame does not open with filler");

endmodule

// File: rtl/sdspi_r1_scan.sv
module sdspi_r1_scan
   import sdspi_cmd_pkg::*;
#(
   parameter int POLL_BYTES = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go_i,
   input  logic       ready_i,
   input  logic [7:0] rx_i,
   output logic       valid_o,
   output logic       fin_o,
   output logic       done_o,
   output logic [7:0] r1_o,
   output logic       no_resp_o
);

   localparam int CW = (POLL_BYTES > 2) ? $clog2(POLL_BYTES) : 1;
   localparam logic [CW-1:0] LAST_POLL = CW'(POLL_BYTES - 1);

   generate
      if (POLL_BYTES < 2) begin : g_bad_budget
         $error("sdspi_r1_scan: POLL_BYTES must be at least 2");
      end
   endgenerate

   logic          active_q;
   logic [CW-1:0] cnt_q;
   logic          hs, accept, exhaust;
   logic          done_q, nr_q;
   logic [7:0]    r1_q;

   assign valid_o = active_q;
   assign hs      = active_q && ready_i;
   assign accept  = hs && (cnt_q != '0) && !rx_i[7];
   assign exhaust = hs && (cnt_q == LAST_POLL);
   assign fin_o   = accept || exhaust;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
         done_q   <= 1'b0;
         r1_q     <= 8'hFF;
         nr_q     <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (go_i) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
         end else if (fin_o) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
            r1_q     <= rx_i;
            nr_q     <= (rx_i == 8'hFF);
         end else if (hs) begin
            cnt_q <= cnt_q + CW'(1);
         end
      end
   end

   assign done_o    = done_q;
   assign r1_o      = r1_q;
   assign no_resp_o = nr_q;

   assert_first_poll_skipped_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hs && cnt_q == '0) |=> !done_o)
      else $error("first poll byte ended the command");

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o)
      else $error("done longer than one cycle");

   assert_noresp_is_ff_R7: assert property (@(posedge clk) disable iff (!rst_n)
      no_resp_o |-> r1_o == 8'hFF)
      else $error("no-response flag with non-FF status");

   assert_hold_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |=> (done_o || $stable(r1_o)))
      else $error("status changed without done");

endmodule

// File: rtl/sdspi_cmd_engine.sv
module sdspi_cmd_engine
   import sdspi_cmd_pkg::*;
#(
   parameter int POLL_BYTES     = 8,
   parameter int CRC_BIT_SERIAL = 0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_i,
   input  logic [5:0]  cmd_idx_i,
   input  logic [31:0] cmd_arg_i,
   output logic        busy_o,
   output logic        xfer_valid_o,
   output logic [7:0]  xfer_tx_o,
   input  logic        xfer_ready_i,
   input  logic [7:0]  xfer_rx_i,
   output logic [7:0]  r1_o,
   output logic        no_resp_o,
   output logic        done_o
);

   phase_e      phase_q;
   logic [5:0]  idx_q;
   logic [31:0] arg_q;
   logic        take;

   logic        f_valid, f_upd, f_fin;
   logic [7:0]  f_tx;
   logic        s_valid, s_fin;
   logic        crc_rdy;
   logic [6:0]  crc_val;

   assign take = start_i && (phase_q == PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         idx_q   <= '0;
         arg_q   <= '0;
      end else begin
         unique case (phase_q)
            PH_IDLE: if (take) begin
               phase_q <= PH_FRAME;
               idx_q   <= cmd_idx_i;
               arg_q   <= cmd_arg_i;
            end
            PH_FRAME: if (f_fin) phase_q <= PH_POLL;
            PH_POLL:  if (s_fin) phase_q <= PH_IDLE;
            default:  phase_q <= PH_IDLE;
         endcase
      end
   end

   sdspi_crc7 #(.BIT_SERIAL(CRC_BIT_SERIAL)) u_crc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (take),
      .upd_i  (f_upd),
      .data_i (f_tx),
      .rdy_o  (crc_rdy),
      .crc_o  (crc_val)
   );

   sdspi_frame_seq u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .go_i      (take),
      .idx_i     (idx_q),
      .arg_i     (arg_q),
      .crc_i     (crc_val),
      .crc_rdy_i (crc_rdy),
      .ready_i   (xfer_ready_i),
      .valid_o   (f_valid),
      .tx_o      (f_tx),
      .crc_upd_o (f_upd),
      .fin_o     (f_fin)
   );

   sdspi_r1_scan #(.POLL_BYTES(POLL_BYTES)) u_scan (
      .clk       (clk),
      .rst_n     (rst_n),
      .go_i      (f_fin),
      .ready_i   (xfer_ready_i),
      .rx_i      (xfer_rx_i),
      .valid_o   (s_valid),
      .fin_o     (s_fin),
      .done_o    (done_o),
      .r1_o      (r1_o),
      .no_resp_o (no_resp_o)
   );

   assign busy_o       = (phase_q != PH_IDLE);
   assign xfer_valid_o = f_valid || s_valid;
   assign xfer_tx_o    = (phase_q == PH_FRAME) ? f_tx : FILL_BYTE;

   assert_tx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid_o && !xfer_ready_i) |=> (xfer_valid_o && $stable(xfer_tx_o)))
      else $error("request dropped or changed before handshake");

   assert_busy_from_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i))
      else $error("busy rose without start");

   assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o)
      else $error("done while still busy");

   assert_one_requester_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(f_valid && s_valid))
      else $error("frame and poll requested together");

endmodule

// File: tb/sdspi_cmd_engine_tb.sv
module sdspi_cmd_engine_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [5:0]  cmd_idx_i = '0;
   logic [31:0] cmd_arg_i = '0;
   logic        busy_o, xfer_valid_o, no_resp_o, done_o;
   logic [7:0]  xfer_tx_o, r1_o;
   logic        xfer_ready_i = 1'b0;
   logic [7:0]  xfer_rx_i = 8'h00;

   always #2 clk = ~clk;

   sdspi_cmd_engine u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .cmd_idx_i(cmd_idx_i), .cmd_arg_i(cmd_arg_i),
      .busy_o(busy_o), .xfer_valid_o(xfer_valid_o), .xfer_tx_o(xfer_tx_o),
      .xfer_ready_i(xfer_ready_i), .xfer_rx_i(xfer_rx_i),
      .r1_o(r1_o), .no_resp_o(no_resp_o), .done_o(done_o)
   );

   int checks = 0;
   int failures = 0;

   logic [7:0] pollq [0:7];
   logic [7:0] txlog [0:31];
   int txn = 0, pp = 0, cyc = 0, last_hs = 0, dly = 0;
   int done_cnt = 0, done_cyc = 0;
   logic [7:0] got_r1;
   logic got_nr;

   task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Shifter model and output monitor, all on the falling edge
   always @(negedge clk) begin
      cyc++;
      if (done_o) begin
         done_cnt++;
         done_cyc = cyc;
         got_r1 = r1_o;
         got_nr = no_resp_o;
      end
      if (xfer_ready_i) begin
         xfer_ready_i = 1'b0;
      end else if (xfer_valid_o && rst_n) begin
         if (dly > 0) dly--;
         else begin
            xfer_ready_i = 1'b1;
            if (txn < 7) xfer_rx_i = 8'h3C;
            else begin
               xfer_rx_i = (pp < 8) ? pollq[pp] : 8'hEE;
               pp++;
            end
            if (txn < 32) txlog[txn] = xfer_tx_o;
            txn++;
            last_hs = cyc;
            dly = $urandom_range(0, 2);
         end
      end
   end

   function automatic logic [6:0] ref_crc7(input logic [39:0] msg);
      logic [6:0] c = '0;
      for (int i = 39; i >= 0; i--) begin
         logic top = c[6];
         c = {c[5:0], 1'b0};
         if (top ^ msg[i]) c = c ^ 7'b0001001;
      end
      return c;
   endfunction

   task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input bit stray);
      logic [7:0] exp_frame [0:6];
      int exp_polls;
      logic [7:0] exp_r1;
      logic [39:0] msg;
      int t0;
      exp_polls = 8;
      exp_r1 = pollq[7];
      for (int i = 1; i < 8; i++) begin
         if (!pollq[i][7]) begin
            exp_polls = i + 1;
            exp_r1 = pollq[i];
            break;
         end
      end
      msg = {2'b01, idx, arg};
      exp_frame[0] = 8'hFF;
      exp_frame[1] = msg[39:32];
      exp_frame[2] = arg[31:24];
      exp_frame[3] = arg[23:16];
      exp_frame[4] = arg[15:8];
      exp_frame[5] = arg[7:0];
      exp_frame[6] = {ref_crc7(msg), 1'b1};

      @(negedge clk);
      txn = 0; pp = 0; done_cnt = 0;
      start_i = 1'b1; cmd_idx_i = idx; cmd_arg_i = arg;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o == 1'b1, "R9 busy after start", busy_o, 1);
      if (stray) begin
         @(negedge clk);
         @(negedge clk);
         chk(busy_o == 1'b1, "R9 busy at stray start", busy_o, 1);
         start_i = 1'b1; cmd_idx_i = ~idx; cmd_arg_i = ~arg;
         @(negedge clk);
         start_i = 1'b0;
      end
      t0 = cyc;
      while (done_cnt == 0 && cyc - t0 < 400) @(negedge clk);
      repeat (6) @(negedge clk);

      chk(done_cnt == 1, "R8 single done pulse", done_cnt, 1);
      chk(txn == 7 + exp_polls, "R4 R6 exchange count", txn, 7 + exp_polls);
      chk(txlog[0] == 8'hFF, "R1 filler byte", txlog[0], 8'hFF);
      chk(txlog[1] == exp_frame[1], "R1 command byte", txlog[1], exp_frame[1]);
      for (int i = 2; i < 6; i++)
         chk(txlog[i] == exp_frame[i], "R2 argument byte", txlog[i], exp_frame[i]);
      chk(txlog[6] == exp_frame[6], "R3 crc byte", txlog[6], exp_frame[6]);
      for (int i = 7; i < txn && i < 32; i++)
         chk(txlog[i] == 8'hFF, "R4 poll filler", txlog[i], 8'hFF);
      chk(done_cyc == last_hs + 1, "R8 done timing", done_cyc, last_hs + 1);
      chk(got_r1 == exp_r1, "R6 R7 status byte", got_r1, exp_r1);
      chk(got_nr == (exp_r1 == 8'hFF), "R7 no-response flag", got_nr, exp_r1 == 8'hFF);
      chk(r1_o == exp_r1, "R8 status held", r1_o, exp_r1);
      chk(busy_o == 1'b0, "R9 idle after done", busy_o, 0);
   endtask

   task automatic fill_polls(input logic [7:0] v);
      for (int i = 0; i < 8; i++) pollq[i] = v;
   endtask

   initial begin
      #(4 * 150000);
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240517));
      repeat (3) @(negedge clk);
      chk(busy_o == 0 && done_o == 0, "R10 reset busy/done", {busy_o, done_o}, 0);
      chk(xfer_valid_o == 0, "R10 reset valid", xfer_valid_o, 0);
      chk(r1_o == 8'hFF && no_resp_o == 0, "R10 reset status", {no_resp_o, r1_o}, 8'hFF);
      rst_n = 1'b1;
      @(negedge clk);

      // Known checksum anchors
      chk({ref_crc7({8'h40, 32'h0}), 1'b1} == 8'h95, "R3 anchor cmd0", {ref_crc7({8'h40, 32'h0}), 1'b1}, 8'h95);
      chk({ref_crc7({8'h48, 32'h1AA}), 1'b1} == 8'h87, "R3 anchor cmd8", {ref_crc7({8'h48, 32'h1AA}), 1'b1}, 8'h87);

      fill_polls(8'hFF); pollq[1] = 8'h01;
      run_cmd(6'd0, 32'h0, 1'b0);

      // R5: bit7-clear byte in the first poll slot must be skipped
      fill_polls(8'hFF); pollq[0] = 8'h00; pollq[2] = 8'h05;
      run_cmd(6'd8, 32'h0000_01AA, 1'b0);

      // R7: no card
      fill_polls(8'hFF);
      run_cmd(6'd55, 32'h0, 1'b0);

      // R7: budget spent, last byte not 0xFF
      fill_polls(8'hC1); pollq[7] = 8'h9A;
      run_cmd(6'd17, 32'h1234_5678, 1'b0);

      // R6: accept on the last slot
      fill_polls(8'hFF); pollq[7] = 8'h04;
      run_cmd(6'd63, 32'hFFFF_FFFF, 1'b0);

      // R9: stray start while busy
      fill_polls(8'hFF); pollq[3] = 8'h00;
      run_cmd(6'd41, 32'h4000_0000, 1'b1);

      for (int n = 0; n < 25; n++) begin
         for (int i = 0; i < 8; i++) begin
            int r = $urandom_range(0, 3);
            if (r == 0)      pollq[i] = {1'b0, 7'($urandom)};
            else if (r == 1) pollq[i] = {1'b1, 7'($urandom)};
            else             pollq[i] = 8'hFF;
         end
         run_cmd(6'($urandom), $urandom, ($urandom_range(0, 3) == 0));
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule